// File: doc/BRIEF.md
# Cycle-Based Programmable Delay Line

This block models a digitally programmable delay line at clock-cycle resolution. A one-bit input is sampled on every rising clock edge. The same value comes back out of `dout` a programmable number of cycles later. That delay is a fixed inherent part plus an 8-bit select code times a per-step increment, and both the inherent part and the increment are parameters in whole cycles. A disable input overrides the output and holds it low.

The select code is not captured inside the block. It picks a tap of the history register live, from whatever value is on the pins in the cycle the output is updated. If the code changes while samples are still travelling through the line, the output reads whatever the new tap holds. A pulse that has already left through the old tap can therefore appear a second time. This is intended behaviour that the model keeps, and users must hold the code stable while a given delay is wanted.

Top module: `programmable_delay_line`

## Requirements
- R1: With the select code held at `a` and `out_dis` low, `dout` after clock edge n equals the `din` value sampled at edge n-D, where D = INHERENT_CYC + STEP_CYC*a.
- R2: Every select code from 0 to 255 is a valid tap, including the shortest (D = INHERENT_CYC) and the longest (D = INHERENT_CYC + 255*STEP_CYC).
- R3: When `out_dis` is high at a clock edge, `dout` is low after that edge, whatever the stored history holds.
- R4: When `out_dis` is low again at an edge, `dout` returns to the selected tap value after that same edge, with no extra cycle.
- R5: The select code is not latched: a new code applied before an edge sets the tap read at that edge.
- R6: Raising the select code after a pulse has left the output makes the same stored pulse appear again at the longer tap. The block does not suppress it.
- R7: Delay is monotonic in the select code: a larger code never gives a shorter measured latency.
- R8: While `rst_n` is low at an edge, the whole history is cleared and `dout` is low. After release, `dout` stays low until samples taken after the reset reach the selected tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Input sample stream |
| dly_sel | input | 8 | Live delay select code |
| out_dis | input | 1 | Output disable, active high |
| dout | output | 1 | Delayed output |

## Verification
The hardest situation to reach from the ports is the spurious replay. It needs a pulse that has already been delivered but is still stored deeper in the history, and then a select change that lands exactly on that stored sample. The bench first flushes the line with zeros and injects one isolated pulse. It lets the pulse emerge at a short tap and counts it, then raises the code so that the longer tap reaches the same sample. It then counts a second output pulse at the predicted cycle. Monotonicity is measured the same way, as the latency of an isolated pulse over a rising sequence of codes.

// File: rtl/pdl_pkg.sv
// Package: shared types and sizing helpers for the programmable delay line.
// Assumes the inherent delay is at least one cycle and the step is at least one.
package pdl_pkg;

    localparam int SEL_BITS = 8;

    typedef logic [SEL_BITS-1:0] dly_code_t;

    // Number of history samples needed so the longest tap is reachable.
    function automatic int hist_depth(input int inherent_cyc, input int step_cyc);
        return inherent_cyc + ((1 << SEL_BITS) - 1) * step_cyc;
    endfunction

endpackage

// File: rtl/pdl_history.sv
// Module: pdl_history
// Shift register holding the most recent DEPTH input samples; bit 0 is the
// newest. Assumes DEPTH >= 2. Synchronous active-low reset clears every bit.
module pdl_history #(
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] hist_q
);

    // Shift the new sample in at the head; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-2:0], din};
        end
    end

endmodule

// File: rtl/pdl_tap_mux.sv
// Module: pdl_tap_mux
// Combinational tap select. The code is used as it arrives, without any
// capture. Assumes DEPTH = INHERENT_CYC + 255*STEP_CYC, so every code lands
// inside the history.
module pdl_tap_mux
    import pdl_pkg::*;
#(
    parameter int INHERENT_CYC = 3,
    parameter int STEP_CYC     = 2,
    parameter int DEPTH        = 513
) (
    input  logic [DEPTH-1:0] hist_q,
    input  dly_code_t        sel,
    output logic             tap_bit
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] tap_idx;

    // Map the code to a history index: delay minus the output register stage.
    always_comb begin
        tap_idx = IDX_W'(INHERENT_CYC - 1) + IDX_W'(STEP_CYC) * IDX_W'(sel);
        tap_bit = hist_q[tap_idx];
    end

endmodule

// File: rtl/pdl_out_stage.sv
// Module: pdl_out_stage
// Output register. Disable has priority over the tap and takes effect at the
// edge where it is sampled. Synchronous active-low reset drives the output low.
module pdl_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic out_dis,
    input  logic tap_bit,
    output logic dout
);

    // Register the selected tap, or zero when disabled or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || out_dis) begin
            dout <= 1'b0;
        end else begin
            dout <= tap_bit;
        end
    end

endmodule

// File: rtl/programmable_delay_line.sv
// Module: programmable_delay_line (top)
// Delays din by INHERENT_CYC + STEP_CYC*dly_sel cycles. The code is read live,
// so changing it while samples are in flight replays stored history.
// Assumes INHERENT_CYC >= 1 and STEP_CYC >= 1.
module programmable_delay_line
    import pdl_pkg::*;
#(
    parameter int INHERENT_CYC = 3,
    parameter int STEP_CYC     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic [SEL_BITS-1:0] dly_sel,
    input  logic                out_dis,
    output logic                dout
);

    localparam int DEPTH = hist_depth(INHERENT_CYC, STEP_CYC);

    logic [DEPTH-1:0] hist_q;
    logic             tap_bit;

    pdl_history #(
        .DEPTH (DEPTH)
    ) hist_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .hist_q (hist_q)
    );

    pdl_tap_mux #(
        .INHERENT_CYC (INHERENT_CYC),
        .STEP_CYC     (STEP_CYC),
        .DEPTH        (DEPTH)
    ) mux_i (
        .hist_q  (hist_q),
        .sel     (dly_sel),
        .tap_bit (tap_bit)
    );

    pdl_out_stage out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_dis (out_dis),
        .tap_bit (tap_bit),
        .dout    (dout)
    );

endmodule

// File: rtl/pdl_checker.sv
// Module: pdl_checker
// Temporal checks on the delay line, attached to the top by bind.
// Assumes the bench drives rst_n low before the first clock edge.
module pdl_checker (
    input logic clk,
    input logic rst_n,
    input logic din,
    input logic out_dis,
    input logic dout,
    input logic hist_head,
    input logic tap_bit
);

    // R8: reset clears the head of the history and the output.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!dout && !hist_head));

    // R1: every running edge captures the input at the head of the history.
    a_r1_head_captures: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hist_head == $past(din)));

    // R3: disable sampled at an edge forces the output low after it.
    a_r3_dis_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && out_dis) |=> !dout);

    // R4, R5: when enabled, the output takes the live tap of the previous cycle.
    a_r4_follows_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !out_dis) |=> (dout == $past(tap_bit)));

endmodule

bind programmable_delay_line pdl_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .out_dis   (out_dis),
    .dout      (dout),
    .hist_head (hist_q[0]),
    .tap_bit   (tap_bit)
);

// File: tb/programmable_delay_line_tb_top.sv
// Directed bench for programmable_delay_line. A sample log indexed by edge
// number gives the expected output for every cycle.
module programmable_delay_line_tb_top;

    localparam int INH  = 3;
    localparam int STEP = 2;
    localparam int LOGN = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [7:0] dly_sel = 8'd0;
    logic       out_dis = 1'b0;
    logic       dout;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int last_edge = 0;
    int last_rst  = 0;
    bit xs [0:LOGN-1];

    programmable_delay_line #(
        .INHERENT_CYC (INH),
        .STEP_CYC     (STEP)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .dly_sel (dly_sel),
        .out_dis (out_dis),
        .dout    (dout)
    );

    always #2 clk = ~clk;

    // Log each sampled input by edge number and note the most recent reset edge.
    always @(posedge clk) begin
        if (cyc < LOGN) xs[cyc] = din;
        if (!rst_n) last_rst = cyc;
        last_edge = cyc;
        cyc = cyc + 1;
    end

    function automatic int dly_of(input logic [7:0] a);
        return INH + STEP * int'(a);
    endfunction

    function automatic logic ref_out(input int n, input int d);
        if (n - d <= last_rst) return 1'b0;
        return xs[n - d];
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: edge %0d dout=%0b expected %0b", req, last_edge, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare after the rising edge.
    task automatic tick(input logic d, input logic ds, input string req);
        logic e;
        @(negedge clk);
        din = d;
        out_dis = ds;
        @(posedge clk);
        #1;
        e = (ds || !rst_n) ? 1'b0 : ref_out(last_edge, dly_of(dly_sel));
        chk(dout, e, req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, "R8 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        dly_sel = 8'd0;
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, "R8 after release");
    endtask

    task automatic t_stream(input logic [7:0] a, input int n, input string req);
        @(negedge clk);
        dly_sel = a;
        for (int i = 0; i < n; i++) tick(1'($urandom_range(1)), 1'b0, req);
    endtask

    task automatic t_disable();
        @(negedge clk);
        dly_sel = 8'd3;
        for (int i = 0; i < 30; i++) tick(1'($urandom_range(1)), 1'b0, "R1 pre-disable");
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b1, "R3 disabled low");
        tick(1'b1, 1'b0, "R4 release to tap");
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, "R4 after release");
    endtask

    task automatic t_replay();
        int ones;
        @(negedge clk);
        dly_sel = 8'd1;
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, "R5 flush");
        tick(1'b1, 1'b0, "R5 pulse in");
        ones = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1'b0, 1'b0, "R5 short tap");
            if (dout === 1'b1) ones++;
        end
        chk(logic'(ones == 1), 1'b1, "R5 one pulse at short tap");
        @(negedge clk);
        dly_sel = 8'd10;
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1'b0, 1'b0, "R6 long tap");
            if (dout === 1'b1) ones++;
        end
        chk(logic'(ones == 1), 1'b1, "R6 spurious replay seen");
    endtask

    task automatic t_monotonic();
        int prev_lat;
        int lat;
        logic [7:0] codes [6] = '{8'd0, 8'd1, 8'd2, 8'd7, 8'd20, 8'd64};
        prev_lat = 0;
        foreach (codes[k]) begin
            @(negedge clk);
            dly_sel = codes[k];
            for (int i = 0; i < 140; i++) tick(1'b0, 1'b0, "R7 flush");
            tick(1'b1, 1'b0, "R7 pulse in");
            lat = -1;
            for (int j = 1; j < 200 && lat < 0; j++) begin
                tick(1'b0, 1'b0, "R7 wait");
                if (dout === 1'b1) lat = j;
            end
            chk(logic'(lat == dly_of(codes[k])), 1'b1, "R7 latency equals delay");
            chk(logic'(lat >= prev_lat), 1'b1, "R7 monotonic");
            prev_lat = lat;
        end
    endtask

    initial begin
        t_reset();
        t_stream(8'd0,   300, "R1 R2 code 0");
        t_stream(8'd17,  300, "R1 code 17");
        t_stream(8'd255, 600, "R2 code 255");
        t_disable();
        t_replay();
        t_monotonic();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule